// File: doc/BRIEF.md
# Ethernet Auto-Negotiation Mode Resolver

This block holds the auto-negotiation control and status state of a 10/100 Ethernet PHY and turns it into one operating mode: a speed, a duplex, and a flag that says the pair is valid. It takes four inputs:

- the local advertised abilities;
- the link partner's base code word, already decoded and presented as a parallel word with a one-cycle strobe;
- link-valid indications from the 10 Mb/s and 100 Mb/s receivers;
- management writes to a control register.

When a code word arrives, the block picks the best mode that both ends share. When only link signalling is seen, it falls back to parallel detection. That path reports half duplex and loads a synthesised partner word. If both receivers report link at the same time, it raises a fault instead. A restart request, a fresh enable, or the loss of the negotiated link first opens a hold window. During that window transmit activity is silenced, and only after it ends does the block listen for the partner again. With negotiation disabled, the mode comes straight from two control bits. The hold length is a parameter in clock cycles.

Top module: `an_mode_resolver`

## Requirements
- R1: After reset with negotiation enabled by default, the block reports: an_done=0, mode_vld=0, tx_quiet=0, lpar_q=0, exp_q=0, pd_fault=0. ctl_rd reads 16'h3100 (bit 12 enable, bit 13 speed, bit 8 duplex, all from reset parameters).
- R2: When a code word strobe is seen while listening, partner abilities are read from lp_word bits 5..8 (10 half, 10 full, 100 half, 100 full). Local abilities come from adv_abil bits 0..3 in the same order. The highest common mode wins in the order 100 full, 100 half, 10 full, 10 half, and an_done rises one cycle after the strobe.
- R3: A code word with no mode in common leaves the block listening (an_done=0). The word is still stored in lpar_q, with exp_q bit 1 (page received) and bit 0 (partner negotiation-able) set.
- R4: While listening with no code word, exactly one valid receiver link completes by parallel detection, always at half duplex. lpar_q becomes 16'h0081 for 100 Mb/s or 16'h0021 for 10 Mb/s, and exp_q bit 0 reads 0.
- R5: Both receiver links valid while listening sets pd_fault and exp_q bit 4 without completing. The fault clears when a new hold window starts.
- R6: With control bit 12 clear, mode_vld=1, mode_100 follows control bit 13 and mode_fdx follows control bit 8. With bit 12 set, writes to bits 13 and 8 do not change the reported mode.
- R7: A control write with bits 12 and 9 set starts a hold window. tx_quiet is high for exactly BREAK_CYC cycles, an_done clears, and listening follows.
- R8: After completion, loss of the receiver link at the resolved speed starts a hold window.
- R9: Negotiation starts from forced mode only on a 0-to-1 change of control bit 12. Writing bit 12 = 1 without bit 9 while it is already 1 leaves the state unchanged.
- R10: mode_vld is high only in forced mode or after completion.
- R11: Code words and link indications during a hold window are ignored.
- R12: A code word and a single receiver link in the same cycle resolve by the code word, not by parallel detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_abil | input | 4 | Local abilities: bit0 10H, bit1 10F, bit2 100H, bit3 100F |
| lp_word | input | 16 | Partner base code word |
| lp_word_vld | input | 1 | One-cycle strobe: lp_word holds a new word |
| link10_ok | input | 1 | 10 Mb/s receiver sees valid link |
| link100_ok | input | 1 | 100 Mb/s receiver sees valid link |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data |
| ctl_rd | output | 16 | Control register read-back |
| mode_100 | output | 1 | Resolved speed is 100 Mb/s |
| mode_fdx | output | 1 | Resolved duplex is full |
| mode_vld | output | 1 | Speed and duplex outputs are meaningful |
| an_done | output | 1 | Negotiation complete |
| lpar_q | output | 16 | Partner ability register value |
| exp_q | output | 5 | Expansion status: bit4 fault, bit1 page received, bit0 partner able |
| pd_fault | output | 1 | Parallel detection fault |
| tx_quiet | output | 1 | Hold window active, transmit and link pulses silenced |

## Verification
The bench builds the block with BREAK_CYC set to 8, with parallel detection enabled, and with negotiation on at reset. The short hold makes the exact width of the silence window measurable edge by edge, and lets every scenario restart between cases at small cost. Forced mode is reached by writes and left again through the enable edge, so both reset-time defaults and runtime transitions are exercised.

// File: rtl/an_pkg.sv
package an_pkg;
   typedef enum logic [1:0] {
      ST_FORCED = 2'd0,
      ST_HOLD   = 2'd1,
      ST_LISTEN = 2'd2,
      ST_DONE   = 2'd3
   } an_st_e;

   localparam int WORD_W      = 16;
   localparam int ABIL_N      = 4;
   localparam int EXP_W       = 5;
   localparam int CB_DUPLEX   = 8;
   localparam int CB_RESTART  = 9;
   localparam int CB_AN_EN    = 12;
   localparam int CB_SPEED    = 13;
   localparam int LP_ABIL_LSB = 5;
   localparam int EX_LP_ABLE  = 0;
   localparam int EX_PAGE     = 1;
   localparam int EX_PD_FLT   = 4;
   localparam logic [WORD_W-1:0] PD_WORD_100 = 16'h0081;
   localparam logic [WORD_W-1:0] PD_WORD_10  = 16'h0021;
endpackage

// File: rtl/an_prio_pick.sv
module an_prio_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0]         local_abil,
   input  logic [N-1:0]         peer_abil,
   output logic                 hit,
   output logic [$clog2(N)-1:0] pick
);
   localparam int IW = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("an_prio_pick: N must be at least 2");
   end

   logic [N-1:0] common;
   assign common = local_abil & peer_abil;

   // higher index means higher priority; the last match in the loop wins
   always_comb begin
      hit  = 1'b0;
      pick = '0;
      for (int i = 0; i < N; i++) begin
         if (common[i]) begin
            hit  = 1'b1;
            pick = IW'(i);
         end
      end
   end
endmodule

// File: rtl/an_par_detect.sv
module an_par_detect (
   input  logic link_lo,
   input  logic link_hi,
   output logic single_ok,
   output logic conflict
);
   assign single_ok = link_lo ^ link_hi;
   assign conflict  = link_lo & link_hi;
endmodule

// File: rtl/an_hold_timer.sv
module an_hold_timer #(
   parameter int HOLD_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expire
);
   localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("an_hold_timer: HOLD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (start) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == LAST) begin
            run_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign expire = run_q && (cnt_q == LAST);
endmodule

// File: rtl/an_mode_resolver.sv
module an_mode_resolver
   import an_pkg::*;
#(
   parameter int BREAK_CYC     = 37_500_000,
   parameter bit PD_EN         = 1'b1,
   parameter bit RST_AN_EN     = 1'b1,
   parameter bit RST_FORCE_100 = 1'b1,
   parameter bit RST_FORCE_FDX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ABIL_N-1:0] adv_abil,
   input  logic [WORD_W-1:0] lp_word,
   input  logic              lp_word_vld,
   input  logic              link10_ok,
   input  logic              link100_ok,
   input  logic              ctl_wr,
   input  logic [WORD_W-1:0] ctl_wdata,
   output logic [WORD_W-1:0] ctl_rd,
   output logic              mode_100,
   output logic              mode_fdx,
   output logic              mode_vld,
   output logic              an_done,
   output logic [WORD_W-1:0] lpar_q,
   output logic [EXP_W-1:0]  exp_q,
   output logic              pd_fault,
   output logic              tx_quiet
);
   localparam int PW = $clog2(ABIL_N);

   if (ABIL_N != 4) begin : g_bad_abil
      $error("an_mode_resolver: ability vector must have four modes");
   end
   if (LP_ABIL_LSB + ABIL_N > WORD_W) begin : g_bad_word
      $error("an_mode_resolver: ability field exceeds code word");
   end

   an_st_e            st_q, st_d;
   logic              en_q, spd_q, dup_q;
   logic [WORD_W-1:0] lpar_d, lpar_r;
   logic              able_q, able_d, page_q, page_d, flt_q, flt_d;
   logic              r100_q, r100_d, rfdx_q, rfdx_d;
   logic              go_hold, hold_expire;
   logic              cw_hit;
   logic [PW-1:0]     cw_pick;
   logic              pd_single, pd_conflict;
   logic              force_req, restart_req, link_cur;

   an_prio_pick #(.N(ABIL_N)) u_pick (
      .local_abil (adv_abil),
      .peer_abil  (lp_word[LP_ABIL_LSB +: ABIL_N]),
      .hit        (cw_hit),
      .pick       (cw_pick)
   );

   if (PD_EN) begin : g_pd
      an_par_detect u_pd (
         .link_lo   (link10_ok),
         .link_hi   (link100_ok),
         .single_ok (pd_single),
         .conflict  (pd_conflict)
      );
   end else begin : g_no_pd
      assign pd_single   = 1'b0;
      assign pd_conflict = 1'b0;
   end

   an_hold_timer #(.HOLD_CYC(BREAK_CYC)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (go_hold),
      .expire (hold_expire)
   );

   assign force_req   = ctl_wr && !ctl_wdata[CB_AN_EN];
   assign restart_req = ctl_wr && ctl_wdata[CB_AN_EN] &&
                        (ctl_wdata[CB_RESTART] || !en_q);
   assign link_cur    = r100_q ? link100_ok : link10_ok;

   always_comb begin
      st_d    = st_q;
      lpar_d  = lpar_r;
      able_d  = able_q;
      page_d  = page_q;
      flt_d   = flt_q;
      r100_d  = r100_q;
      rfdx_d  = rfdx_q;
      go_hold = 1'b0;
      if (force_req) begin
         st_d   = ST_FORCED;
         lpar_d = '0;
         able_d = 1'b0;
         page_d = 1'b0;
         flt_d  = 1'b0;
      end else if (restart_req) begin
         st_d    = ST_HOLD;
         go_hold = 1'b1;
         lpar_d  = '0;
         able_d  = 1'b0;
         page_d  = 1'b0;
         flt_d   = 1'b0;
      end else begin
         unique case (st_q)
            ST_HOLD: begin
               if (hold_expire) st_d = ST_LISTEN;
            end
            ST_LISTEN: begin
               if (lp_word_vld) begin
                  lpar_d = lp_word;
                  able_d = 1'b1;
                  page_d = 1'b1;
                  if (cw_hit) begin
                     st_d   = ST_DONE;
                     r100_d = cw_pick[1];
                     rfdx_d = cw_pick[0];
                  end
               end else if (pd_single) begin
                  st_d   = ST_DONE;
                  r100_d = link100_ok;
                  rfdx_d = 1'b0;
                  able_d = 1'b0;
                  lpar_d = link100_ok ? PD_WORD_100 : PD_WORD_10;
               end else if (pd_conflict) begin
                  flt_d = 1'b1;
               end
            end
            ST_DONE: begin
               if (!link_cur) begin
                  st_d    = ST_HOLD;
                  go_hold = 1'b1;
                  lpar_d  = '0;
                  able_d  = 1'b0;
                  page_d  = 1'b0;
                  flt_d   = 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= RST_AN_EN ? ST_LISTEN : ST_FORCED;
         en_q   <= RST_AN_EN;
         spd_q  <= RST_FORCE_100;
         dup_q  <= RST_FORCE_FDX;
         lpar_r <= '0;
         able_q <= 1'b0;
         page_q <= 1'b0;
         flt_q  <= 1'b0;
         r100_q <= 1'b0;
         rfdx_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         lpar_r <= lpar_d;
         able_q <= able_d;
         page_q <= page_d;
         flt_q  <= flt_d;
         r100_q <= r100_d;
         rfdx_q <= rfdx_d;
         if (ctl_wr) begin
            en_q  <= ctl_wdata[CB_AN_EN];
            spd_q <= ctl_wdata[CB_SPEED];
            dup_q <= ctl_wdata[CB_DUPLEX];
         end
      end
   end

   always_comb begin
      ctl_rd            = '0;
      ctl_rd[CB_AN_EN]  = en_q;
      ctl_rd[CB_SPEED]  = spd_q;
      ctl_rd[CB_DUPLEX] = dup_q;
      exp_q             = '0;
      exp_q[EX_LP_ABLE] = able_q;
      exp_q[EX_PAGE]    = page_q;
      exp_q[EX_PD_FLT]  = flt_q;
   end

   assign lpar_q   = lpar_r;
   assign pd_fault = flt_q;
   assign an_done  = (st_q == ST_DONE);
   assign tx_quiet = (st_q == ST_HOLD);
   assign mode_vld = (st_q == ST_FORCED) || (st_q == ST_DONE);
   assign mode_100 = (st_q == ST_FORCED) ? spd_q : (st_q == ST_DONE) ? r100_q : 1'b0;
   assign mode_fdx = (st_q == ST_FORCED) ? dup_q : (st_q == ST_DONE) ? rfdx_q : 1'b0;
endmodule

// File: rtl/an_mode_resolver_chk.sv
module an_mode_resolver_chk #(
   parameter int BREAK_CYC = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic [3:0]  adv_abil,
   input logic [15:0] lp_word,
   input logic        lp_word_vld,
   input logic        link10_ok,
   input logic        link100_ok,
   input logic        ctl_wr,
   input logic [15:0] ctl_wdata,
   input logic [15:0] ctl_rd,
   input logic        mode_100,
   input logic        mode_fdx,
   input logic        mode_vld,
   input logic        an_done,
   input logic [15:0] lpar_q,
   input logic [4:0]  exp_q,
   input logic        pd_fault,
   input logic        tx_quiet
);
   localparam int RW = $clog2(BREAK_CYC + 2);

   logic [RW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!tx_quiet || (ctl_wr && ctl_wdata[12])) begin
         run_q <= '0;
      end else if (run_q != {RW{1'b1}}) begin
         run_q <= run_q + 1'b1;
      end
   end

   p_quiet_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_quiet |-> (run_q < RW'(BREAK_CYC)));

   p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[12] && ctl_wdata[9]) |=> (tx_quiet && !an_done));

   p_pd_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (an_done && !exp_q[0]) |-> (!mode_fdx && (lpar_q == 16'h0081 || lpar_q == 16'h0021)));

   p_fault_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_fault) |-> $past(link10_ok && link100_ok));

   p_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rd[12] |-> (mode_vld && mode_100 == ctl_rd[13] && mode_fdx == ctl_rd[8]));

   p_linkloss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (an_done && !ctl_wr && !(mode_100 ? link100_ok : link10_ok)) |=> tx_quiet);

   p_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mode_vld |-> (an_done || !ctl_rd[12]));

   p_hold_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_quiet && !ctl_wr) |=> !an_done);
endmodule

bind an_mode_resolver an_mode_resolver_chk #(.BREAK_CYC(BREAK_CYC)) u_chk (.*);

// File: tb/sim_an_mode_resolver.sv
module sim_an_mode_resolver;
   localparam int B = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  adv_abil = 4'hF;
   logic [15:0] lp_word = '0;
   logic        lp_word_vld = 1'b0;
   logic        link10_ok = 1'b0;
   logic        link100_ok = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [15:0] ctl_rd;
   logic        mode_100, mode_fdx, mode_vld, an_done, pd_fault, tx_quiet;
   logic [15:0] lpar_q;
   logic [4:0]  exp_q;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   an_mode_resolver #(.BREAK_CYC(B), .PD_EN(1'b1), .RST_AN_EN(1'b1),
                      .RST_FORCE_100(1'b1), .RST_FORCE_FDX(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .adv_abil(adv_abil), .lp_word(lp_word),
      .lp_word_vld(lp_word_vld), .link10_ok(link10_ok), .link100_ok(link100_ok),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd),
      .mode_100(mode_100), .mode_fdx(mode_fdx), .mode_vld(mode_vld),
      .an_done(an_done), .lpar_q(lpar_q), .exp_q(exp_q),
      .pd_fault(pd_fault), .tx_quiet(tx_quiet));

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      ctl_wr = 1'b1;
      ctl_wdata = d;
      tick();
      ctl_wr = 1'b0;
   endtask

   task automatic restart();
      link10_ok = 1'b0;
      link100_ok = 1'b0;
      lp_word_vld = 1'b0;
      wr(16'h1200);
      repeat (B) tick();
   endtask

   task automatic cw(input logic [15:0] w, input logic l10, input logic l100);
      link10_ok = l10;
      link100_ok = l100;
      lp_word = w;
      lp_word_vld = 1'b1;
      tick();
      lp_word_vld = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "an_done", an_done, 0);
      chk("R1", "mode_vld", mode_vld, 0);
      chk("R1", "tx_quiet", tx_quiet, 0);
      chk("R1", "lpar", lpar_q, 0);
      chk("R1", "exp", exp_q, 0);
      chk("R1", "fault", pd_fault, 0);
      chk("R1", "ctl_rd", ctl_rd, 32'h3100);
   endtask

   task automatic t_prio();
      restart();
      adv_abil = 4'hF;
      cw(16'h01E1, 1'b0, 1'b1);
      chk("R2", "done 100F", an_done, 1);
      chk("R2", "mode 100F", {mode_vld, mode_100, mode_fdx}, 3'b111);
      chk("R2", "lpar", lpar_q, 32'h01E1);
      restart();
      cw(16'h00E1, 1'b0, 1'b1);
      chk("R2", "mode 100H", {an_done, mode_100, mode_fdx}, 3'b110);
      restart();
      adv_abil = 4'b0011;
      cw(16'h01E1, 1'b1, 1'b0);
      chk("R2", "mode 10F", {an_done, mode_100, mode_fdx}, 3'b101);
      restart();
      adv_abil = 4'hF;
      cw(16'h0021, 1'b1, 1'b0);
      chk("R2", "mode 10H", {an_done, mode_100, mode_fdx}, 3'b100);
   endtask

   task automatic t_cw_wins();
      restart();
      cw(16'h0041, 1'b1, 1'b0);
      chk("R12", "code word over pd", {an_done, mode_100, mode_fdx}, 3'b101);
      chk("R12", "exp bits", exp_q, 5'b00011);
   endtask

   task automatic t_nocommon();
      restart();
      adv_abil = 4'b0001;
      cw(16'h0180, 1'b0, 1'b0);
      chk("R3", "not done", an_done, 0);
      chk("R3", "lpar stored", lpar_q, 32'h0180);
      chk("R3", "exp bits", exp_q, 5'b00011);
      tick();
      chk("R10", "vld while listening", mode_vld, 0);
      adv_abil = 4'hF;
   endtask

   task automatic t_pd();
      restart();
      link10_ok = 1'b1;
      tick();
      chk("R4", "pd10 mode", {an_done, mode_100, mode_fdx}, 3'b100);
      chk("R4", "pd10 lpar", lpar_q, 32'h0021);
      chk("R4", "pd10 able bit", exp_q[0], 0);
      restart();
      link100_ok = 1'b1;
      tick();
      chk("R4", "pd100 mode", {an_done, mode_100, mode_fdx}, 3'b110);
      chk("R4", "pd100 lpar", lpar_q, 32'h0081);
   endtask

   task automatic t_pd_fault();
      restart();
      link10_ok = 1'b1;
      link100_ok = 1'b1;
      tick();
      chk("R5", "fault set", {pd_fault, exp_q[4]}, 2'b11);
      chk("R5", "not done", an_done, 0);
      link10_ok = 1'b0;
      tick();
      chk("R5", "single link completes", {an_done, mode_100}, 2'b11);
      wr(16'h1200);
      chk("R5", "fault cleared at hold", pd_fault, 0);
      link100_ok = 1'b0;
      repeat (B) tick();
   endtask

   task automatic t_restart_len();
      restart();
      cw(16'h01E1, 1'b0, 1'b1);
      wr(16'h1200);
      chk("R7", "quiet starts", tx_quiet, 1);
      chk("R7", "done cleared", an_done, 0);
      repeat (B - 1) tick();
      chk("R7", "quiet last cycle", tx_quiet, 1);
      chk("R10", "vld low in hold", mode_vld, 0);
      link100_ok = 1'b0;
      tick();
      chk("R7", "quiet ended", tx_quiet, 0);
   endtask

   task automatic t_linkloss();
      restart();
      cw(16'h01E1, 1'b0, 1'b1);
      chk("R8", "done before loss", an_done, 1);
      link100_ok = 1'b0;
      tick();
      chk("R8", "quiet after loss", {tx_quiet, an_done}, 2'b10);
      repeat (B) tick();
   endtask

   task automatic t_hold_ignore();
      restart();
      wr(16'h1200);
      cw(16'h01E1, 1'b0, 1'b1);
      chk("R11", "code word in hold", {an_done, tx_quiet}, 2'b01);
      link100_ok = 1'b0;
      link10_ok = 1'b1;
      tick();
      chk("R11", "link in hold", an_done, 0);
      link10_ok = 1'b0;
      repeat (B) tick();
   endtask

   task automatic t_forced();
      wr(16'h2100);
      chk("R6", "forced 100F", {mode_vld, mode_100, mode_fdx}, 3'b111);
      chk("R6", "ctl_rd", ctl_rd, 32'h2100);
      wr(16'h0000);
      chk("R6", "forced 10H", {mode_vld, mode_100, mode_fdx}, 3'b100);
      cw(16'h01E1, 1'b0, 1'b1);
      chk("R6", "code word in forced", {an_done, mode_100}, 2'b00);
      link100_ok = 1'b0;
   endtask

   task automatic t_enable_edge();
      wr(16'h1000);
      chk("R9", "enable edge starts hold", tx_quiet, 1);
      repeat (B) tick();
      cw(16'h01E1, 1'b0, 1'b1);
      chk("R9", "done after edge", an_done, 1);
      wr(16'h1000);
      chk("R9", "re-enable no hold", {tx_quiet, an_done}, 2'b01);
      chk("R6", "speed bits ignored", {mode_100, mode_fdx}, 2'b11);
      link100_ok = 1'b0;
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_prio();
      t_cw_wins();
      t_nocommon();
      t_pd();
      t_pd_fault();
      t_restart_len();
      t_linkloss();
      t_hold_ignore();
      t_forced();
      t_enable_edge();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule